// File: doc/BRIEF.md
# Vector Integer Merge/Move Unit

This unit carries out the masked merge and the unmasked move of integers into one destination vector register group, one element per clock. A start pulse delivers a 32-bit instruction word, from which the unit takes the operand form, the move/merge choice and a 5-bit immediate. With it come the element width code, the mask stride, the active length and the group maximum. The unit then walks element indices upward from zero. For each active element it writes one of three values: a source vector element, a scalar truncated to the element width, or the immediate sign-extended to the element width. In merge, a per-element mask bit decides between that value and the element of a second vector. After the active elements, every remaining index up to the group maximum is written with zero.

The register file stays outside. The unit drives one element index to both vector read ports and one bit position to the mask read port, and expects the read data in the same cycle. Results leave through a write port that carries an index and a 64-bit value.

Control is a four-state machine. IDLE waits; a start with a known form moves it to BODY (or straight to FINISH when the active length is zero). BODY writes active elements and moves to TAIL after the last one if the length is below the maximum, else to FINISH. TAIL writes zeros and moves to FINISH after index vlmax−1. FINISH raises done for one cycle and returns to IDLE.

Top module: `vmm_unit`

## Requirements
- R1: `sew` codes 0, 1, 2, 3 select 8, 16, 32, 64-bit elements. Read data and the scalar may carry any upper bits, and every written value has all bits above the element width at zero.
- R2: In merge (instruction bit 25 = 0), an active element takes the chosen first value when its mask bit is 1 and the `vs2_data` element when it is 0.
- R3: The mask bit for element i is requested at bit position i × `mlen` through `mask_pos`, and `mask_rd_en` is high while it is needed.
- R4: In move (instruction bit 25 = 1), every active element takes the chosen first value, and `mask_rd_en` stays low for the whole operation.
- R5: In the immediate form, the first value is instruction bits 19:15 sign-extended to the element width.
- R6: In the scalar form, the first value is the low element-width bits of `scalar`.
- R7: Indices from `vl` through `vlmax`−1 are written with zero, after all active elements.
- R8: With `vl` = 0 there is no write at all, and `done` is high in the first cycle after the start edge.
- R9: Instruction bits 14:12 select the form: 000 vector (`vs1_data`), 100 scalar, 011 immediate. A start carrying any other value is ignored and `busy` stays low.
- R10: Writes use consecutive cycles and ascending indices starting at 0, one per cycle, the first in the cycle after the start edge. `done` is a single-cycle pulse in the cycle after the last write, and `busy` is high from the start edge through that cycle.
- R11: While `busy` is high, `start` and all configuration inputs are ignored. The running operation finishes with the settings it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| instr | input | 32 | Instruction word (bit 25 move/merge, bits 19:15 immediate, bits 14:12 form) |
| sew | input | 2 | Element width code |
| mlen | input | MLEN_W | Mask bit stride per element |
| vl | input | CNT_W | Active element count |
| vlmax | input | CNT_W | Group element count |
| scalar | input | ELEN | Scalar operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | output | CNT_W | Element index for both vector reads |
| vs1_data | input | ELEN | First vector element at rd_idx |
| vs2_data | input | ELEN | Second vector element at rd_idx |
| mask_rd_en | output | 1 | Mask bit needed this cycle |
| mask_pos | output | POS_W | Mask bit position |
| mask_bit | input | 1 | Mask bit at mask_pos |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | CNT_W | Destination element index |
| wr_data | output | ELEN | Destination element value |

## Verification
The assertions assume that `vl` never exceeds `vlmax`, and that `vlmax` never exceeds the group size divided by the element bytes. They also assume that `vlmax` × `mlen` fits inside the mask register, so the index and position counters never wrap. The sweep obeys these rules: it takes `vlmax` as the full group count or three below it, and `vl` from 0, 1, about half and full. It uses `mlen` of 1, or the largest stride that still fits. Read data, mask and scalar come from bench functions with dirty upper bits, and a second start with different settings is injected in the middle of some runs.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
    localparam int ELEN = 64;

    typedef enum logic [1:0] {
        SRC_VEC,
        SRC_SCL,
        SRC_IMM
    } src_form_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_TAIL,
        ST_FINISH
    } vmm_state_t;

    localparam logic [2:0] F3_VEC = 3'b000;
    localparam logic [2:0] F3_SCL = 3'b100;
    localparam logic [2:0] F3_IMM = 3'b011;
    localparam int MOVE_BIT = 25;
endpackage

// File: rtl/vmm_decode.sv
module vmm_decode
    import vmm_pkg::*;
(
    input  logic [31:0] instr,
    output logic        valid,
    output src_form_t   form,
    output logic        is_move,
    output logic [4:0]  imm5
);
    logic [2:0] f3;

    assign f3      = instr[14:12];
    assign is_move = instr[MOVE_BIT];
    assign imm5    = instr[19:15];

    always_comb begin
        valid = 1'b1;
        form  = SRC_VEC;
        unique case (f3)
            F3_VEC:  form = SRC_VEC;
            F3_SCL:  form = SRC_SCL;
            F3_IMM:  form = SRC_IMM;
            default: valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/vmm_ctrl.sv
module vmm_ctrl
    import vmm_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int POS_W  = 9,
    parameter int MLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  vl,
    input  logic [CNT_W-1:0]  vlmax,
    input  logic [MLEN_W-1:0] mlen,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic              in_tail,
    output logic [CNT_W-1:0]  elem_idx,
    output logic [POS_W-1:0]  mask_pos
);
    vmm_state_t        state, nxt;
    logic [CNT_W-1:0]  vl_q, vlmax_q, idx_q;
    logic [MLEN_W-1:0] mlen_q;
    logic [POS_W-1:0]  pos_q;
    logic              last_body, last_tail;

    assign last_body = (idx_q == vl_q - CNT_W'(1));
    assign last_tail = (idx_q == vlmax_q - CNT_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = (vl == '0) ? ST_FINISH : ST_BODY;
            ST_BODY:   if (last_body) nxt = (vl_q < vlmax_q) ? ST_TAIL : ST_FINISH;
            ST_TAIL:   if (last_tail) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q    <= '0;
            vlmax_q <= '0;
            mlen_q  <= '0;
            idx_q   <= '0;
            pos_q   <= '0;
        end else if (state == ST_IDLE && go) begin
            vl_q    <= vl;
            vlmax_q <= vlmax;
            mlen_q  <= mlen;
            idx_q   <= '0;
            pos_q   <= '0;
        end else if (state == ST_BODY || state == ST_TAIL) begin
            idx_q <= idx_q + CNT_W'(1);
            pos_q <= pos_q + POS_W'(mlen_q);
        end
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        wr_en   = 1'b0;
        in_tail = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_BODY: begin
                busy  = 1'b1;
                wr_en = 1'b1;
            end
            ST_TAIL: begin
                busy    = 1'b1;
                wr_en   = 1'b1;
                in_tail = 1'b1;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign elem_idx = idx_q;
    assign mask_pos = pos_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (elem_idx == $past(elem_idx) + CNT_W'(1)));

    // R7
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (elem_idx < vlmax_q));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(vl_q) && $stable(vlmax_q) && $stable(mlen_q)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en);
endmodule

// File: rtl/vmm_operand.sv
module vmm_operand
    import vmm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            in_tail,
    input  logic [1:0]      sew,
    input  src_form_t       form,
    input  logic            is_move,
    input  logic [4:0]      imm5,
    input  logic [ELEN-1:0] scalar,
    input  logic [ELEN-1:0] vs1,
    input  logic [ELEN-1:0] vs2,
    input  logic            mask_bit,
    output logic [ELEN-1:0] wr_data
);
    logic [ELEN-1:0] width_msk, first_val, picked;

    assign width_msk = ~({ELEN{1'b1}} << (32'd8 << sew));

    always_comb begin
        first_val = '0;
        unique case (form)
            SRC_VEC: first_val = vs1;
            SRC_SCL: first_val = scalar;
            SRC_IMM: first_val = {{(ELEN-5){imm5[4]}}, imm5};
            default: first_val = '0;
        endcase
    end

    assign picked  = (is_move || mask_bit) ? first_val : vs2;
    assign wr_data = in_tail ? '0 : (picked & width_msk);

    // R1
    width_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data & ~width_msk) == '0));
endmodule

// File: rtl/vmm_unit.sv
module vmm_unit
    import vmm_pkg::*;
#(
    parameter int GRP_BITS = 512,
    localparam int CNT_W  = $clog2(GRP_BITS / 8 + 1),
    localparam int POS_W  = $clog2(GRP_BITS),
    localparam int MLEN_W = $clog2(ELEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [1:0]        sew,
    input  logic [MLEN_W-1:0] mlen,
    input  logic [CNT_W-1:0]  vl,
    input  logic [CNT_W-1:0]  vlmax,
    input  logic [ELEN-1:0]   scalar,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  rd_idx,
    input  logic [ELEN-1:0]   vs1_data,
    input  logic [ELEN-1:0]   vs2_data,
    output logic              mask_rd_en,
    output logic [POS_W-1:0]  mask_pos,
    input  logic              mask_bit,
    output logic              wr_en,
    output logic [CNT_W-1:0]  wr_idx,
    output logic [ELEN-1:0]   wr_data
);
    logic             dec_valid, dec_move, go, in_tail;
    src_form_t        dec_form, form_q;
    logic [4:0]       dec_imm, imm_q;
    logic [1:0]       sew_q;
    logic             move_q;
    logic [ELEN-1:0]  scalar_q;
    logic [CNT_W-1:0] elem_idx;

    vmm_decode u_dec (
        .instr   (instr),
        .valid   (dec_valid),
        .form    (dec_form),
        .is_move (dec_move),
        .imm5    (dec_imm)
    );

    assign go = start && !busy && dec_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sew_q    <= '0;
            form_q   <= SRC_VEC;
            move_q   <= 1'b0;
            imm_q    <= '0;
            scalar_q <= '0;
        end else if (go) begin
            sew_q    <= sew;
            form_q   <= dec_form;
            move_q   <= dec_move;
            imm_q    <= dec_imm;
            scalar_q <= scalar;
        end
    end

    vmm_ctrl #(.CNT_W(CNT_W), .POS_W(POS_W), .MLEN_W(MLEN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .vl       (vl),
        .vlmax    (vlmax),
        .mlen     (mlen),
        .busy     (busy),
        .done     (done),
        .wr_en    (wr_en),
        .in_tail  (in_tail),
        .elem_idx (elem_idx),
        .mask_pos (mask_pos)
    );

    vmm_operand u_opnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .in_tail  (in_tail),
        .sew      (sew_q),
        .form     (form_q),
        .is_move  (move_q),
        .imm5     (imm_q),
        .scalar   (scalar_q),
        .vs1      (vs1_data),
        .vs2      (vs2_data),
        .mask_bit (mask_bit),
        .wr_data  (wr_data)
    );

    assign rd_idx     = elem_idx;
    assign wr_idx     = elem_idx;
    assign mask_rd_en = wr_en && !in_tail && !move_q;

    // R4
    move_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && move_q) |-> !mask_rd_en);

    // R7
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_tail) |-> (wr_data == '0));

    // R3
    mask_only_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rd_en |-> (wr_en && busy));
endmodule

// File: tb/sim_vmm_unit.sv
module sim_vmm_unit;
    localparam int GRP    = 512;
    localparam int CNT_W  = 7;
    localparam int POS_W  = 9;
    localparam int MLEN_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic [1:0]        sew = '0;
    logic [MLEN_W-1:0] mlen = '0;
    logic [CNT_W-1:0]  vl = '0;
    logic [CNT_W-1:0]  vlmax = '0;
    logic [63:0]       scalar = '0;
    logic              busy, done, mask_rd_en, mask_bit, wr_en;
    logic [CNT_W-1:0]  rd_idx, wr_idx;
    logic [POS_W-1:0]  mask_pos;
    logic [63:0]       vs1_data, vs2_data, wr_data;

    always #5 clk = ~clk;

    vmm_unit #(.GRP_BITS(GRP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .sew(sew),
        .mlen(mlen), .vl(vl), .vlmax(vlmax), .scalar(scalar), .busy(busy),
        .done(done), .rd_idx(rd_idx), .vs1_data(vs1_data), .vs2_data(vs2_data),
        .mask_rd_en(mask_rd_en), .mask_pos(mask_pos), .mask_bit(mask_bit),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    function automatic logic [63:0] src1_f(int i);
        return 64'h9E37_79B9_7F4A_7C15 ^ (64'(i) * 64'h0101_0303_0707_0B0B);
    endfunction

    function automatic logic [63:0] src2_f(int i);
        return 64'hC2B2_AE3D_27D4_EB4F + (64'(i) * 64'h1357_9BDF_2468_ACE1);
    endfunction

    function automatic logic mask_f(int p);
        logic [8:0] q;
        q = 9'(p);
        return q[0] ^ q[2] ^ q[3] ^ q[5] ^ q[6] ^ (q[7] & q[8]);
    endfunction

    assign vs1_data = src1_f(int'(rd_idx));
    assign vs2_data = src2_f(int'(rd_idx));
    assign mask_bit = mask_f(int'(mask_pos));

    int total = 0;
    int bad = 0;
    int nwr, order_err, mask_in_move;
    bit mon_move;
    logic [63:0] got [64];

    always @(negedge clk) begin
        if (wr_en) begin
            got[wr_idx] = wr_data;
            if (int'(wr_idx) != nwr) order_err++;
            nwr++;
        end
        if (mask_rd_en && mon_move) mask_in_move++;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 act=%0d exp=%0d", wd, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_instr(logic [2:0] f3, bit mv, logic [4:0] imm);
        return {6'b010111, mv, 5'd2, imm, f3, 5'd4, 7'b1010111};
    endfunction

    function automatic logic [63:0] exp_elem(int i, int s, logic [2:0] f3, bit mv,
                                             int nvl, int mln, logic [63:0] sc,
                                             logic [4:0] imm);
        logic [63:0] msk, first;
        msk = (s == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
        if (i >= nvl) return 64'd0;
        if (f3 == 3'b000)      first = src1_f(i);
        else if (f3 == 3'b100) first = sc;
        else                   first = {{59{imm[4]}}, imm};
        if (!mv && !mask_f((i * mln) % GRP)) return src2_f(i) & msk;
        return first & msk;
    endfunction

    task automatic run(int s, logic [2:0] f3, bit mv, int nvl, int nmax, int mln,
                       logic [63:0] sc, logic [4:0] imm, bit inject);
        int cyc, ewr, ecyc;
        string tag;
        nwr = 0;
        order_err = 0;
        mask_in_move = 0;
        mon_move = mv;
        for (int i = 0; i < 64; i++) got[i] = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        instr  = mk_instr(f3, mv, imm);
        sew    = 2'(s);
        vl     = CNT_W'(nvl);
        vlmax  = CNT_W'(nmax);
        mlen   = MLEN_W'(mln);
        scalar = sc;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 3) begin
                start  = 1'b1;
                vl     = CNT_W'(1);
                sew    = 2'(3 - s);
                scalar = ~sc;
                instr  = mk_instr(3'b011, ~mv, ~imm);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        ewr  = (nvl == 0) ? 0 : nmax;
        ecyc = (nvl == 0) ? 1 : nmax + 1;
        tag  = inject ? "R11" : ((nvl == 0) ? "R8" : "R10");
        chk(cyc == ecyc, {tag, " done cycle"}, 64'(cyc), 64'(ecyc));
        chk(nwr == ewr, {tag, " write count"}, 64'(nwr), 64'(ewr));
        chk(order_err == 0, "R10 write order", 64'(order_err), 64'd0);
        if (mv) chk(mask_in_move == 0, "R4 mask read in move", 64'(mask_in_move), 64'd0);
        for (int i = 0; i < ewr; i++) begin
            logic [63:0] e;
            e = exp_elem(i, s, f3, mv, nvl, mln, sc, imm);
            if (i >= nvl)             tag = "R7 tail";
            else if (inject)          tag = "R11 element";
            else if (!mv)             tag = "R2 R3 merge";
            else if (f3 == 3'b100)    tag = "R6 R4 scalar move";
            else if (f3 == 3'b011)    tag = "R5 R4 imm move";
            else                      tag = "R1 R4 vector move";
            chk(got[i] === e, tag, got[i], e);
        end
        @(negedge clk);
        chk(!busy && !wr_en && !done, "R10 idle after done",
            64'({busy, wr_en, done}), 64'd0);
    endtask

    initial begin
        logic [2:0] f3s [3];
        f3s[0] = 3'b000;
        f3s[1] = 3'b100;
        f3s[2] = 3'b011;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en, "R10 reset state", 64'({busy, done, wr_en}), 64'd0);

        // R9: unknown form code is ignored
        instr = mk_instr(3'b001, 1'b0, 5'd3);
        vl    = CNT_W'(4);
        vlmax = CNT_W'(8);
        nwr   = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy, "R9 unknown form no busy", 64'(busy), 64'd0);
            @(negedge clk);
        end
        chk(nwr == 0, "R9 unknown form no write", 64'(nwr), 64'd0);

        for (int s = 0; s < 4; s++) begin
            int full;
            full = 64 >> s;
            for (int fi = 0; fi < 3; fi++) begin
                for (int mv = 0; mv < 2; mv++) begin
                    for (int mi = 0; mi < 2; mi++) begin
                        for (int p = 0; p < 5; p++) begin
                            int nvl, nmax, mln;
                            logic [63:0] sc;
                            logic [4:0] imm;
                            nmax = (p == 4) ? full - 3 : full;
                            case (p)
                                0: nvl = 0;
                                1: nvl = 1;
                                2: nvl = full / 2 + 1;
                                3: nvl = full;
                                default: nvl = 2;
                            endcase
                            mln = (mi == 1) ? (8 << s) : 1;
                            sc  = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(s * 7 + p) << 5);
                            imm = (p % 2 == 1) ? 5'b10110 : 5'b01011;
                            run(s, f3s[fi], mv[0], nvl, nmax, mln, sc, imm,
                                (p == 3 && mi == 0));
                        end
                    end
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule